// File: doc/BRIEF.md
# Rotate-Through-Carry Unit, 8/16-bit Selectable

This block performs a one-position rotate through the carry flag for an accumulator-style datapath. The carry is part of the ring. On a left rotate the incoming carry fills the vacated low bit and the bit pushed off the top becomes the new carry. On a right rotate the incoming carry fills the vacated top bit and the bit pushed off the bottom becomes the new carry. A width-mode input picks the active width for each operation: the low 8 bits or the full 16 bits. The unit also returns the negative and zero flags for the active-width result.

In narrow mode with the accumulator as target, the upper byte of the 16-bit operand is returned unchanged, so the result can be written straight back to the accumulator. In narrow mode with a memory target, the upper byte of the result is zero.

Operands enter through a valid/ready port and results leave through a valid/ready port, with one register stage between them. A request is accepted when `in_valid` and `in_ready` are both high at a rising edge. Its result is presented with `out_valid` high from the next cycle on. The result is held stable until the consumer raises `out_ready`. While a result is waiting and `out_ready` is low, `in_ready` is low. When `out_ready` is high, a new request can be accepted in the same cycle the old result is taken, so the unit sustains one operation per cycle.

Top module: `rot_carry_unit`

## Requirements
- R1: Left rotate (`in_dir`=0) puts the result bit i equal to operand bit i-1 within the active width, puts `in_carry` into bit 0, and sets `out_carry` to the top bit of the active width of the operand (bit 7 narrow, bit 15 wide).
- R2: Right rotate (`in_dir`=1) puts the result bit i equal to operand bit i+1 within the active width, puts `in_carry` into the top bit of the active width (bit 7 narrow, bit 15 wide), and sets `out_carry` to operand bit 0.
- R3: `in_narrow`=1 selects 8-bit width and `in_narrow`=0 selects 16-bit width; the width is chosen per request.
- R4: With `in_narrow`=1 and `in_to_acc`=1, `out_result[15:8]` equals `in_operand[15:8]`.
- R5: With `in_narrow`=1 and `in_to_acc`=0, `out_result[15:8]` is zero.
- R6: `out_neg` equals the top bit of the active-width result, and `out_zero` is 1 exactly when the active-width result is all zeros; in narrow mode the upper byte does not affect either flag.
- R7: `out_carry` is always written from the bit shifted out. It is cleared when that bit is 0, even when `in_carry` is 1.
- R8: `in_ready` is high whenever no result is pending or `out_ready` is high. An accepted request's result appears with `out_valid`=1 in the following cycle.
- R9: While `out_valid`=1 and `out_ready`=0, all result outputs and `out_valid` stay unchanged, and a request offered meanwhile is neither accepted nor lost.
- R10: While `rst_n` is low and after it is released, `out_valid` is 0 and `in_ready` is 1 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can accept a request |
| in_operand | input | 16 | Operand; low byte is used in narrow mode |
| in_dir | input | 1 | 0 = rotate left, 1 = rotate right |
| in_narrow | input | 1 | 1 = 8-bit width, 0 = 16-bit width |
| in_carry | input | 1 | Incoming carry flag |
| in_to_acc | input | 1 | 1 = target is the accumulator (keep the upper byte in narrow mode) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Rotated value |
| out_carry | output | 1 | New carry flag |
| out_neg | output | 1 | New negative flag |
| out_zero | output | 1 | New zero flag |

## Verification
The bench targets the values where a wrong tap point shows up:
- **0x8000 in narrow mode.** A unit that took carry from bit 15 instead of bit 7 would report carry 1 where 0 is required.
- **0x0080 in wide mode.** A unit that took carry from bit 7 would do the opposite.
- **0x0100 in narrow mode.** This is the zero-flag trap: a zero flag computed over all 16 bits would stay clear.
- **Narrow-mode upper byte.** Every narrow case checks the upper byte for both targets, so a unit that rotated into bit 8 or dropped the kept accumulator byte would return the wrong value.
- **Carry with `in_carry` = 1.** Cases with carry-in 1 and a zero bit shifted out catch a unit that only ever sets the carry.
- **Stall.** A stalled result followed by a waiting request catches a stage that overwrites a held result or drops the waiting request.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic {
    ROT_LEFT  = 1'b0,
    ROT_RIGHT = 1'b1
  } rot_dir_e;

  typedef struct packed {
    logic carry;
    logic neg;
    logic zero;
  } rot_flags_t;
endpackage

// File: rtl/rot_shift_core.sv
module rot_shift_core
  import rot_pkg::*;
#(
  parameter int unsigned WIDE_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic [WIDE_W-1:0] opnd,
  input  rot_dir_e          dir,
  input  logic              narrow,
  input  logic              cin,
  input  logic              keep_upper,
  output logic [WIDE_W-1:0] res,
  output logic              cout
);
  localparam int unsigned UP_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0]   wide_res;
  logic                wide_co;
  logic [NARROW_W-1:0] lo_opnd;
  logic [NARROW_W-1:0] lo_res;
  logic                lo_co;
  logic [WIDE_W-1:0]   nar_full;

  // full-width ring: operand bits plus carry
  always_comb begin
    if (dir == ROT_RIGHT) begin
      wide_res = {cin, opnd[WIDE_W-1:1]};
      wide_co  = opnd[0];
    end else begin
      wide_res = {opnd[WIDE_W-2:0], cin};
      wide_co  = opnd[WIDE_W-1];
    end
  end

  // narrow ring on the low lane only
  assign lo_opnd = opnd[NARROW_W-1:0];
  always_comb begin
    if (dir == ROT_RIGHT) begin
      lo_res = {cin, lo_opnd[NARROW_W-1:1]};
      lo_co  = lo_opnd[0];
    end else begin
      lo_res = {lo_opnd[NARROW_W-2:0], cin};
      lo_co  = lo_opnd[NARROW_W-1];
    end
  end

  // upper lane: kept for an accumulator target, cleared otherwise
  generate
    if (UP_W > 0) begin : g_upper
      logic [UP_W-1:0] upper;
      assign upper    = keep_upper ? opnd[WIDE_W-1:NARROW_W] : '0;
      assign nar_full = {upper, lo_res};
    end else begin : g_no_upper
      logic unused_keep;
      assign unused_keep = keep_upper;
      assign nar_full    = lo_res;
    end
  endgenerate

  assign res  = narrow ? nar_full : wide_res;
  assign cout = narrow ? lo_co    : wide_co;
endmodule

// File: rtl/rot_flag_gen.sv
module rot_flag_gen #(
  parameter int unsigned WIDE_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic [WIDE_W-1:0] res,
  input  logic              narrow,
  output logic              neg,
  output logic              zero
);
  always_comb begin
    if (narrow) begin
      neg  = res[NARROW_W-1];
      zero = ~|res[NARROW_W-1:0];
    end else begin
      neg  = res[WIDE_W-1];
      zero = ~|res;
    end
  end
endmodule

// File: rtl/rot_out_stage.sv
module rot_out_stage
  import rot_pkg::*;
#(
  parameter int unsigned WIDE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIDE_W-1:0] d_res,
  input  rot_flags_t        d_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] q_res,
  output rot_flags_t        q_flags
);
  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_res     <= '0;
      q_flags   <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        q_res     <= d_res;
        q_flags   <= d_flags;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_ready_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_accept_shows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_res) && $stable(q_flags)));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/rot_carry_unit.sv
module rot_carry_unit
  import rot_pkg::*;
#(
  parameter int unsigned WIDE_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WIDE_W-1:0] in_operand,
  input  logic              in_dir,
  input  logic              in_narrow,
  input  logic              in_carry,
  input  logic              in_to_acc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_neg,
  output logic              out_zero
);
  logic [WIDE_W-1:0] rot_res;
  logic              rot_co;
  logic              flg_n;
  logic              flg_z;
  rot_flags_t        d_flags;
  rot_flags_t        q_flags;
  rot_dir_e          dir;

  assign dir = rot_dir_e'(in_dir);

  rot_shift_core #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_core (
    .opnd       (in_operand),
    .dir        (dir),
    .narrow     (in_narrow),
    .cin        (in_carry),
    .keep_upper (in_to_acc),
    .res        (rot_res),
    .cout       (rot_co)
  );

  rot_flag_gen #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_flags (
    .res    (rot_res),
    .narrow (in_narrow),
    .neg    (flg_n),
    .zero   (flg_z)
  );

  assign d_flags = '{carry: rot_co, neg: flg_n, zero: flg_z};

  rot_out_stage #(.WIDE_W(WIDE_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_res     (rot_res),
    .d_flags   (d_flags),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_res     (out_result),
    .q_flags   (q_flags)
  );

  assign out_carry = q_flags.carry;
  assign out_neg   = q_flags.neg;
  assign out_zero  = q_flags.zero;

  logic fire;
  assign fire = in_valid && in_ready;

  assert_left_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_dir && !in_narrow) |=> (out_carry == $past(in_operand[WIDE_W-1])));

  assert_left_carry_narrow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_dir && in_narrow) |=> (out_carry == $past(in_operand[NARROW_W-1])));

  assert_right_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_dir) |=> (out_carry == $past(in_operand[0])));

  assert_keep_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_narrow && in_to_acc) |=>
      (out_result[WIDE_W-1:NARROW_W] == $past(in_operand[WIDE_W-1:NARROW_W])));

  assert_clear_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_narrow && !in_to_acc) |=> (out_result[WIDE_W-1:NARROW_W] == '0));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> !out_neg);
endmodule

// File: tb/rot_carry_unit_tb.sv
module rot_carry_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_operand;
  logic        in_dir;
  logic        in_narrow;
  logic        in_carry;
  logic        in_to_acc;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_result;
  logic        out_carry;
  logic        out_neg;
  logic        out_zero;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rot_carry_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_dir(in_dir), .in_narrow(in_narrow),
    .in_carry(in_carry), .in_to_acc(in_to_acc),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_carry(out_carry),
    .out_neg(out_neg), .out_zero(out_zero)
  );

  // {operand, dir, narrow, cin, to_acc, result, carry, neg, zero}
  localparam int NV = 22;
  localparam logic [38:0] VEC [NV] = '{
    {16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1},
    {16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b0},
    {16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1},
    {16'h8000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0001, 1'b1, 1'b0, 1'b0},
    {16'h0001, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1},
    {16'h0001, 1'b1, 1'b0, 1'b1, 1'b0, 16'h8000, 1'b1, 1'b1, 1'b0},
    {16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h4000, 1'b0, 1'b0, 1'b0},
    {16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b0},
    {16'hAB80, 1'b0, 1'b1, 1'b0, 1'b1, 16'hAB00, 1'b1, 1'b0, 1'b1},
    {16'hAB80, 1'b0, 1'b1, 1'b1, 1'b1, 16'hAB01, 1'b1, 1'b0, 1'b0},
    {16'h5501, 1'b1, 1'b1, 1'b0, 1'b1, 16'h5500, 1'b1, 1'b0, 1'b1},
    {16'h5501, 1'b1, 1'b1, 1'b1, 1'b1, 16'h5580, 1'b1, 1'b1, 1'b0},
    {16'h0040, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0080, 1'b0, 1'b1, 1'b0},
    {16'hFF00, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFF80, 1'b0, 1'b1, 1'b0},
    {16'hFF01, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0003, 1'b0, 1'b0, 1'b0},
    {16'h12C3, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0061, 1'b1, 1'b0, 1'b0},
    {16'h0080, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0100, 1'b0, 1'b0, 1'b0},
    {16'h4000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b0},
    {16'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 16'h891A, 1'b0, 1'b1, 1'b0},
    {16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1},
    {16'h8000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1},
    {16'h0100, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0100, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [38:0] v);
    in_operand = v[38:23];
    in_dir     = v[22];
    in_narrow  = v[21];
    in_carry   = v[20];
    in_to_acc  = v[19];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    drive(39'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 out_valid in reset", {15'd0, out_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after reset", {15'd0, out_valid}, 16'd0);
    chk("R10 in_ready after reset", {15'd0, in_ready}, 16'd1);

    // vector table: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R8 out_valid vec %0d", i), {15'd0, out_valid}, 16'd1);
      chk($sformatf("R1/R2/R3/R4/R5 result vec %0d", i), out_result, VEC[i][18:3]);
      chk($sformatf("R7 carry vec %0d", i), {15'd0, out_carry}, {15'd0, VEC[i][2]});
      chk($sformatf("R6 neg vec %0d", i), {15'd0, out_neg}, {15'd0, VEC[i][1]});
      chk($sformatf("R6 zero vec %0d", i), {15'd0, out_zero}, {15'd0, VEC[i][0]});
    end
    @(negedge clk);
    chk("R8 out_valid drops when idle", {15'd0, out_valid}, 16'd0);

    // back-pressure: R9
    out_ready = 1'b0;
    drive(VEC[5]);
    in_valid = 1'b1;
    @(negedge clk);
    drive(VEC[8]);
    chk("R9 in_ready low while stalled", {15'd0, in_ready}, 16'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 held result", out_result, 16'h8000);
    chk("R9 held carry", {15'd0, out_carry}, 16'd1);
    chk("R9 held valid", {15'd0, out_valid}, 16'd1);
    chk("R8 in_ready follows out_ready", {15'd0, in_ready}, 16'd0);
    out_ready = 1'b1;
    #1;
    chk("R8 in_ready with out_ready", {15'd0, in_ready}, 16'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 waiting request delivered", out_result, 16'hAB00);
    chk("R9 waiting request zero flag", {15'd0, out_zero}, 16'd1);
    @(negedge clk);
    chk("R8 drained", {15'd0, out_valid}, 16'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule